// File: doc/BRIEF.md
# Hot-Swap Fault Log and Host Alert

This block keeps the fault bookkeeping of a hot-swap power controller. It shows a live status word, built from the pass-switch state, the board-present level, the general-purpose pin level and five fault-present flags. It also keeps a sticky fault word with one bit for each of six fault kinds. Fault event strobes from the analog and timer logic set the sticky bits. Several hardware sources clear them, and so do host writes. A power-bad event counts only while the pass switch is on.

The host chooses, one bit per fault kind, which logged faults pull the active-low interrupt line. The line stays low until the serial-bus slave reports a read of the alert-response address. For as long as the line is held, the block raises a responder flag so that the slave returns its own address during that read. The serial-bus state machine is outside this block. It presents register writes as a strobe with a select and data, and it reads through a combinational read port.

Top module: `hsf_fault_top`

## Requirements
- R1: A synchronous active-high reset clears every fault bit and every alert-enable bit. After reset, alert_n_o is 1 and ara_resp_o is 0.
- R2: An event strobe on evt_i[k] sets fault bit k on the next clock edge. The bit stays set until a clear source acts on it. Bit positions are: 0 overcurrent, 1 overvoltage, 2 undervoltage, 3 power-bad, 4 FET-short, 5 board-present-changed. Bits 7:6 of the fault word read 0.
- R3: A power-bad strobe (evt_i[3]) is ignored while fet_on_i is 0.
- R4: Reading select 0 returns the status word with no delay. The layout is: bit 0 fet_on_i, bits 5:1 live_flt_i[4:0], bit 6 bd_prst_i, bit 7 gpio_lvl_i. Select 1 returns the fault word, select 2 returns the enable word, and select 3 returns 0.
- R5: A write strobe with select 1 clears every fault bit whose data bit is 0. A data bit of 1 leaves its fault bit unchanged.
- R6: A high-to-low change of on_pin_i, or of fet_ctl_i, between two consecutive cycles clears all fault bits at the following edge.
- R7: While uv_reset_i or rail_rst_i is 1, all fault bits are cleared at each edge.
- R8: A high-to-low change of bd_prst_i clears every fault bit except bit 5 (board-present-changed).
- R9: When a fault event and any clear source act on the same bit in the same cycle, the event wins and the bit ends up set.
- R10: A write strobe with select 2 loads enable bits 5:0, which use the same positions as the fault word. An event whose enable bit is 1 drives alert_n_o to 0 and ara_resp_o to 1 at the next edge. An event whose enable bit is 0 leaves both unchanged. Selects 0 and 3 ignore writes.
- R11: An ara_read_i strobe while the alert is held releases it at the next edge. The alert then stays released while faults remain logged, until a new enabled event arrives. If an enabled event arrives in the same cycle as the strobe, the alert stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_flt_i | input | 5 | Live fault-present flags (OC, OV, UV, PB, FS) |
| evt_i | input | 6 | Fault event strobes, one per fault bit |
| fet_on_i | input | 1 | Pass switch is on |
| bd_prst_i | input | 1 | Board-present level |
| gpio_lvl_i | input | 1 | General-purpose pin level |
| on_pin_i | input | 1 | ON input level |
| fet_ctl_i | input | 1 | FET-on control bit from the control register |
| uv_reset_i | input | 1 | Undervoltage below reset level |
| rail_rst_i | input | 1 | Supply or internal-rail reset |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Write register select |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 8 | Read data |
| ara_read_i | input | 1 | Alert-response address read strobe |
| alert_n_o | output | 1 | Active-low interrupt, 0 means pull low |
| ara_resp_o | output | 1 | Return own address on alert-response read |

## Verification
The status word is combinational, so it is due in the same cycle its inputs change. Fault bits, enable bits and the alert state each change at the first edge after the strobe or clear that drives them. The edge-detected clears (ON, FET control, board present) take effect at the edge after the falling level is first seen. The bench drives every input at the falling clock edge. A behavioural reference model updates at the rising edge, and all outputs are compared at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    localparam int NFLT  = 6;
    localparam int NLIVE = 5;
    localparam int REG_W = 8;
    localparam int SEL_W = 2;

    typedef enum logic [2:0] {
        F_OC  = 3'd0,
        F_OV  = 3'd1,
        F_UV  = 3'd2,
        F_PB  = 3'd3,
        F_FS  = 3'd4,
        F_BPC = 3'd5
    } flt_idx_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_STAT = 2'd0,
        SEL_FLT  = 2'd1,
        SEL_AEN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic on_fall;
        logic ctl_fall;
        logic bp_fall;
        logic hw_level;
    } clr_src_t;

    typedef struct packed {
        logic             gpio;
        logic             bd_prst;
        logic [NLIVE-1:0] live;
        logic             fet_on;
    } status_t;

    // Bits that survive the clear sources active this cycle.
    function automatic logic [NFLT-1:0] keep_mask(clr_src_t c);
        logic [NFLT-1:0] m;
        if (c.on_fall || c.ctl_fall || c.hw_level) begin
            m = '0;
        end else if (c.bp_fall) begin
            m = '0;
            m[int'(F_BPC)] = 1'b1;
        end else begin
            m = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hsf_fall_det.sv
module hsf_fall_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    logic [W-1:0] lvl_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) lvl_q[i] <= 1'b0;
            else     lvl_q[i] <= lvl[i];
        end
        assign fall[i] = lvl_q[i] & ~lvl[i];
    end
endmodule

// File: rtl/hsf_fault_log.sv
module hsf_fault_log
    import hsf_pkg::*;
#(
    parameter int N = NFLT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  clr_src_t     clr,
    input  logic         wr_fault,
    input  logic [N-1:0] wr_mask,
    output logic [N-1:0] flt_q
);
    logic [N-1:0] keep;
    logic [N-1:0] wkeep;

    assign keep  = keep_mask(clr);
    assign wkeep = wr_fault ? wr_mask : '1;

    always_ff @(posedge clk) begin
        if (rst) flt_q <= '0;
        else     flt_q <= (flt_q & keep & wkeep) | evt;
    end

    // R9
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flt_q & $past(evt)) == $past(evt)));

    // R7
    hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr.hw_level && !(|evt)) |=> (flt_q == '0));

    // R8
    bp_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr.bp_fall && !clr.on_fall && !clr.ctl_fall && !clr.hw_level
         && !wr_fault && !(|evt))
        |=> (flt_q[N-2:0] == '0) && (flt_q[N-1] == $past(flt_q[N-1])));

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|evt) && (clr == '0) && !wr_fault) |=> $stable(flt_q));
endmodule

// File: rtl/hsf_alert_ctl.sv
module hsf_alert_ctl
    import hsf_pkg::*;
#(
    parameter int N = NFLT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_wr,
    input  logic [N-1:0] en_data,
    input  logic [N-1:0] evt,
    input  logic         ara_read,
    output logic [N-1:0] en_q,
    output logic         pend_q
);
    logic new_hit;

    assign new_hit = |(evt & en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            if (en_wr) en_q <= en_data;
            if (new_hit)       pend_q <= 1'b1;
            else if (ara_read) pend_q <= 1'b0;
        end
    end

    // R11
    ara_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && ara_read && !new_hit) |=> !pend_q);

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !new_hit) |=> !pend_q);

    // R10
    hit_raise_chk: assert property (@(posedge clk) disable iff (rst)
        new_hit |=> pend_q);
endmodule

// File: rtl/hsf_fault_top.sv
module hsf_fault_top
    import hsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NLIVE-1:0] live_flt_i,
    input  logic [NFLT-1:0]  evt_i,
    input  logic             fet_on_i,
    input  logic             bd_prst_i,
    input  logic             gpio_lvl_i,
    input  logic             on_pin_i,
    input  logic             fet_ctl_i,
    input  logic             uv_reset_i,
    input  logic             rail_rst_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             ara_read_i,
    output logic             alert_n_o,
    output logic             ara_resp_o
);
    logic [NFLT-1:0] evt_g;
    logic [2:0]      edge_lvl;
    logic [2:0]      edge_fall;
    clr_src_t        clr;
    logic [NFLT-1:0] flt_q;
    logic [NFLT-1:0] en_q;
    logic            pend_q;
    logic            wr_flt;
    logic            wr_aen;
    status_t         stat;
    logic            unused_hi;

    // Power-bad counts only while the pass switch is on.
    always_comb begin
        evt_g              = evt_i;
        evt_g[int'(F_PB)]  = evt_i[int'(F_PB)] & fet_on_i;
    end

    assign edge_lvl = {on_pin_i, fet_ctl_i, bd_prst_i};

    hsf_fall_det #(.W(3)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (edge_lvl),
        .fall (edge_fall)
    );

    assign clr.on_fall  = edge_fall[2];
    assign clr.ctl_fall = edge_fall[1];
    assign clr.bp_fall  = edge_fall[0];
    assign clr.hw_level = uv_reset_i | rail_rst_i;

    assign wr_flt    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_FLT);
    assign wr_aen    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_AEN);
    assign unused_hi = ^wr_data_i[REG_W-1:NFLT];

    hsf_fault_log #(.N(NFLT)) u_log (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_g),
        .clr      (clr),
        .wr_fault (wr_flt),
        .wr_mask  (wr_data_i[NFLT-1:0]),
        .flt_q    (flt_q)
    );

    hsf_alert_ctl #(.N(NFLT)) u_alert (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (wr_aen),
        .en_data  (wr_data_i[NFLT-1:0]),
        .evt      (evt_g),
        .ara_read (ara_read_i),
        .en_q     (en_q),
        .pend_q   (pend_q)
    );

    assign stat.gpio    = gpio_lvl_i;
    assign stat.bd_prst = bd_prst_i;
    assign stat.live    = live_flt_i;
    assign stat.fet_on  = fet_on_i;

    always_comb begin
        case (reg_sel_e'(rd_sel_i))
            SEL_STAT: rd_data_o = stat;
            SEL_FLT:  rd_data_o = REG_W'(flt_q);
            SEL_AEN:  rd_data_o = REG_W'(en_q);
            default:  rd_data_o = '0;
        endcase
    end

    assign alert_n_o  = ~pend_q;
    assign ara_resp_o = pend_q;

    // R3
    pb_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!fet_on_i && !flt_q[int'(F_PB)]) |=> !flt_q[int'(F_PB)]);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (flt_q == '0) && (en_q == '0) && alert_n_o && !ara_resp_o);

    // R11
    alert_pair_chk: assert property (@(posedge clk) disable iff (rst)
        alert_n_o != ara_resp_o);
endmodule

// File: tb/tb_hsf_fault_top.sv
`timescale 1ns/1ps
module tb_hsf_fault_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] live_flt_i = '0;
    logic [5:0] evt_i = '0;
    logic       fet_on_i = 1'b0, bd_prst_i = 1'b0, gpio_lvl_i = 1'b0;
    logic       on_pin_i = 1'b0, fet_ctl_i = 1'b0;
    logic       uv_reset_i = 1'b0, rail_rst_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [1:0] rd_sel_i = '0;
    logic [7:0] rd_data_o;
    logic       ara_read_i = 1'b0;
    logic       alert_n_o, ara_resp_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference model state
    bit [5:0] m_flt, m_en;
    bit       m_pend, m_on_q, m_fc_q, m_bp_q;

    always #4 clk = ~clk;

    hsf_fault_top dut (
        .clk(clk), .rst(rst), .live_flt_i(live_flt_i), .evt_i(evt_i),
        .fet_on_i(fet_on_i), .bd_prst_i(bd_prst_i), .gpio_lvl_i(gpio_lvl_i),
        .on_pin_i(on_pin_i), .fet_ctl_i(fet_ctl_i), .uv_reset_i(uv_reset_i),
        .rail_rst_i(rail_rst_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .ara_read_i(ara_read_i), .alert_n_o(alert_n_o), .ara_resp_o(ara_resp_o)
    );

    always @(posedge clk) begin
        bit [5:0] ev, f;
        bit hit;
        if (rst) begin
            m_flt = 0; m_en = 0; m_pend = 0;
            m_on_q = 0; m_fc_q = 0; m_bp_q = 0;
        end else begin
            ev = evt_i;
            if (!fet_on_i) ev[3] = 0;
            f = m_flt;
            if (wr_en_i && wr_sel_i == 2'd1) f = f & wr_data_i[5:0];
            if ((m_on_q && !on_pin_i) || (m_fc_q && !fet_ctl_i) || uv_reset_i || rail_rst_i)
                f = 0;
            if (m_bp_q && !bd_prst_i) f = f & 6'b100000;
            f = f | ev;
            hit = (ev & m_en) != 0;
            if (hit) m_pend = 1;
            else if (ara_read_i) m_pend = 0;
            if (wr_en_i && wr_sel_i == 2'd2) m_en = wr_data_i[5:0];
            m_flt = f;
            m_on_q = on_pin_i; m_fc_q = fet_ctl_i; m_bp_q = bd_prst_i;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        case (rd_sel_i)
            2'd0: return {gpio_lvl_i, bd_prst_i, live_flt_i, fet_on_i};
            2'd1: return {2'b00, m_flt};
            2'd2: return {2'b00, m_en};
            default: return 8'h00;
        endcase
    endfunction

    // every-clock comparison against the model: R4 status, R2 fault, R10 enable, R11 alert
    task automatic compare_all();
        string t;
        t = (rd_sel_i == 2'd0) ? "R4 read" : (rd_sel_i == 2'd2) ? "R10 read" : "R2 read";
        chk(t, rd_data_o, exp_rd());
        chk("R11 alert", {6'd0, alert_n_o, ara_resp_o}, {6'd0, ~m_pend, m_pend});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        evt_i = '0; wr_en_i = 0; ara_read_i = 0;
    endtask

    task automatic fire(logic [5:0] e);
        evt_i = e; tick();
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        wr_en_i = 1; wr_sel_i = s; wr_data_i = d; tick();
    endtask

    task automatic read_fault(string tag, logic [7:0] exp);
        rd_sel_i = 2'd1; tick();
        chk(tag, rd_data_o, exp);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        rd_sel_i = 2'd1; tick();
        // R1 reset state
        chk("R1 fault", rd_data_o, 8'h00);
        chk("R1 alert", {alert_n_o, ara_resp_o}, 2'b10);
        rd_sel_i = 2'd2; tick();
        chk("R1 enable", rd_data_o, 8'h00);

        // R10 enables for OC and FS, read back
        wr(2'd2, 8'h11);
        chk("R10 enable", rd_data_o, 8'h11);
        wr(2'd0, 8'hFF);  // select 0 ignores writes
        rd_sel_i = 2'd2; tick();
        chk("R10 sel0 ignored", rd_data_o, 8'h11);

        // R2 / R10 enabled OC event raises the alert
        fire(6'b000001);
        chk("R10 alert low", {alert_n_o, ara_resp_o}, 2'b01);
        read_fault("R2 OC logged", 8'h01);

        // R11 release, then disabled OV event keeps it released
        ara_read_i = 1; tick();
        chk("R11 released", {alert_n_o, ara_resp_o}, 2'b10);
        fire(6'b000010);
        chk("R11 stays released", {alert_n_o, ara_resp_o}, 2'b10);
        read_fault("R2 OV logged", 8'h03);

        // R3 power-bad gated by FET state
        fet_on_i = 0; fire(6'b001000);
        read_fault("R3 PB ignored", 8'h03);
        fet_on_i = 1; fire(6'b001000);
        read_fault("R3 PB logged", 8'h0B);

        // R5 host write of zeros clears only those bits
        wr(2'd1, 8'hFE);
        read_fault("R5 partial clear", 8'h0A);

        // R6 ON falling edge
        on_pin_i = 1; tick();
        on_pin_i = 0; tick();
        read_fault("R6 ON clear", 8'h00);

        // R6 FET control falling edge
        fire(6'b010100);
        fet_ctl_i = 1; tick();
        fet_ctl_i = 0; tick();
        read_fault("R6 ctl clear", 8'h00);

        // R7 level clears
        fire(6'b000111);
        uv_reset_i = 1; tick(); uv_reset_i = 0;
        read_fault("R7 UV reset clear", 8'h00);
        fire(6'b110000);
        rail_rst_i = 1; tick(); rail_rst_i = 0;
        read_fault("R7 rail clear", 8'h00);

        // R8 board-present falling keeps only bit 5
        fire(6'b100011);
        bd_prst_i = 1; tick();
        bd_prst_i = 0; tick();
        read_fault("R8 keep BPC", 8'h20);

        // R9 event wins over same-cycle clear
        rail_rst_i = 1; evt_i = 6'b000010; tick(); rail_rst_i = 0;
        read_fault("R9 set wins", 8'h02);

        // R11 event in the same cycle as the response read
        fire(6'b010000);
        chk("R10 FS alert", {alert_n_o, ara_resp_o}, 2'b01);
        ara_read_i = 1; evt_i = 6'b000001; tick();
        chk("R11 set wins over release", {alert_n_o, ara_resp_o}, 2'b01);
        ara_read_i = 1; tick();
        chk("R11 release", {alert_n_o, ara_resp_o}, 2'b10);

        // R4 status layout, several patterns
        rd_sel_i = 2'd0;
        live_flt_i = 5'b10101; fet_on_i = 1; gpio_lvl_i = 0; bd_prst_i = 1; tick();
        chk("R4 status a", rd_data_o, 8'b0110_1011);
        live_flt_i = 5'b01010; fet_on_i = 0; gpio_lvl_i = 1; bd_prst_i = 0; tick();
        chk("R4 status b", rd_data_o, 8'b1001_0100);
        rd_sel_i = 2'd3; tick();
        chk("R4 sel3 zero", rd_data_o, 8'h00);

        // mixed traffic compared against the model each cycle
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            rd_sel_i   = r[1:0];
            live_flt_i = r[6:2];
            fet_on_i   = r[7];
            gpio_lvl_i = r[8];
            if (r[12:9] == 0) bd_prst_i = ~bd_prst_i;
            if (r[16:13] == 0) on_pin_i = ~on_pin_i;
            if (r[20:17] == 0) fet_ctl_i = ~fet_ctl_i;
            uv_reset_i = (r[25:21] == 0);
            rail_rst_i = (r[30:26] == 0);
            evt_i = (r[31]) ? 6'($urandom) : 6'd0;
            if ($urandom_range(0, 7) == 0) begin
                wr_en_i = 1; wr_sel_i = 2'($urandom); wr_data_i = 8'($urandom);
            end
            ara_read_i = ($urandom_range(0, 5) == 0);
            tick();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule